// File: doc/BRIEF.md
# Memory Data Signature Generator

This block reads a range of 16-bit words from a synchronous memory and compresses them into one 16-bit signature. Software or a host tool computes the same signature from the data it meant to store. It then compares the two values to confirm that the memory holds what was written. A single start pulse launches the computation. The caller supplies a start word address and a word count. Addresses count in words, not bytes.

The signature register is a 16-bit multiple-input shift register and is seeded with all ones at every launch. For each word, a feedback bit is formed as the XOR of register bits 15, 4, 2 and 1. The register is shifted left by one place with the feedback bit entering at bit 0. The data word is then XORed into the result. The range is walked twice. The first pass climbs from the first word to the last. The second pass descends from the last word back to the first, so the last word is absorbed twice in a row. The memory returns data one cycle after the address. A small tag pipeline keeps each update aligned with the word it belongs to.

Top module: `mem_sig_gen`

## Requirements
- R1: While reset is high and in the cycle after it, `busy_o` and `done_o` are 0, `mem_re_o` is 0 and `sig_o` reads 16'hFFFF.
- R2: Each computation starts from 16'hFFFF. For each word d, the register s is updated to s' = d ^ {s[14:0], s[15]^s[4]^s[2]^s[1]}.
- R3: The first pass issues reads at start, start+1, ..., start+count-1 on consecutive cycles. Addresses wrap modulo 2^AW.
- R4: The second pass issues reads at start+count-1 down to start, straight after the first pass. Exactly 2×count reads are made, and the last address is read twice back to back.
- R5: Read data is taken exactly one cycle after its address. Every returned word is absorbed once, with none dropped or repeated at the turn between passes.
- R6: A start with a count of 0 raises `done_o` in the next cycle. `sig_o` then reads 16'hFFFF, and no read is issued.
- R7: A start pulse that arrives while `busy_o` is high has no effect on the addresses, the result or the number of done pulses.
- R8: While `busy_o` is low, `sig_o` holds its value until a start is accepted.
- R9: For a nonzero count, `busy_o` is high from the cycle after the accepted start until the last word has been absorbed. `done_o` is then a one-cycle pulse with `busy_o` low, and `sig_o` carries the final value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse, taken only while idle |
| start_addr_i | input | AW | First word address of the range |
| word_cnt_i | input | CW | Number of words in the range |
| mem_addr_o | output | AW | Memory read word address |
| mem_re_o | output | 1 | Memory read enable |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after the address |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sig_o | output | 16 | Signature value |

## Verification
The hardest case to reach is the turn between the passes, where the same address is issued twice and the absorbed word must not be lost or duplicated. The bench reaches it with random ranges of many lengths. A count of 1 makes the turn coincide with both the first and the last read, and one range crosses the top of the address space. A second start pulse is injected in the middle of a long run to show that it leaves the read stream and the result unchanged. A zero-count launch is placed between ordinary runs.

// File: rtl/sig_pkg.sv
package sig_pkg;

    localparam int SIG_W = 16;
    localparam logic [SIG_W-1:0] SIG_SEED = '1;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_UP,
        WALK_DOWN
    } walk_state_e;

    typedef struct packed {
        logic vld;
        logic last;
    } rd_tag_t;

    // One shift-and-fold step of the signature register.
    function automatic logic [SIG_W-1:0] misr_step(
        input logic [SIG_W-1:0] cur,
        input logic [SIG_W-1:0] word
    );
        logic fb;
        fb = cur[15] ^ cur[4] ^ cur[2] ^ cur[1];
        return word ^ {cur[SIG_W-2:0], fb};
    endfunction

endpackage

// File: rtl/sig_addr_seq.sv
module sig_addr_seq
    import sig_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] cnt_i,
    output logic          active_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          rd_en_o,
    output logic          rd_last_o
);

    walk_state_e   st_q;
    logic [AW-1:0] base_q;
    logic [CW-1:0] top_idx_q;
    logic [CW-1:0] idx_q;

    logic at_top;
    logic at_bottom;

    assign at_top    = (idx_q == top_idx_q);
    assign at_bottom = (idx_q == '0);

    always_comb begin
        active_o  = (st_q != WALK_IDLE);
        rd_en_o   = active_o;
        rd_addr_o = base_q + AW'(idx_q);
        rd_last_o = (st_q == WALK_DOWN) && at_bottom;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= WALK_IDLE;
            base_q    <= '0;
            top_idx_q <= '0;
            idx_q     <= '0;
        end else begin
            unique case (st_q)
                WALK_IDLE: begin
                    if (launch_i) begin
                        st_q      <= WALK_UP;
                        base_q    <= base_i;
                        top_idx_q <= cnt_i - CW'(1);
                        idx_q     <= '0;
                    end
                end
                WALK_UP: begin
                    // The top index is issued once here and once more as the
                    // first read of the descending pass.
                    if (at_top) begin
                        st_q <= WALK_DOWN;
                    end else begin
                        idx_q <= idx_q + CW'(1);
                    end
                end
                WALK_DOWN: begin
                    if (at_bottom) begin
                        st_q <= WALK_IDLE;
                    end else begin
                        idx_q <= idx_q - CW'(1);
                    end
                end
                default: st_q <= WALK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sig_rd_track.sv
module sig_rd_track
    import sig_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rd_en_i,
    input  logic    rd_last_i,
    output rd_tag_t tag_o
);

    // Matches the one-cycle read latency of the memory.
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_o <= '0;
        end else begin
            tag_o.vld  <= rd_en_i;
            tag_o.last <= rd_en_i & rd_last_i;
        end
    end

endmodule

// File: rtl/sig_misr.sv
module sig_misr
    import sig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             seed_i,
    input  logic             absorb_i,
    input  logic [SIG_W-1:0] word_i,
    output logic [SIG_W-1:0] sig_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_o <= SIG_SEED;
        end else if (seed_i) begin
            sig_o <= SIG_SEED;
        end else if (absorb_i) begin
            sig_o <= misr_step(sig_o, word_i);
        end
    end

endmodule

// File: rtl/mem_sig_gen.sv
module mem_sig_gen
    import sig_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [CW-1:0] word_cnt_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_re_o,
    input  logic [15:0]   mem_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [15:0]   sig_o
);

    logic    accept;
    logic    cnt_zero;
    logic    launch;
    logic    seq_active;
    logic    seq_last;
    rd_tag_t tag;
    logic    done_q;

    assign cnt_zero = (word_cnt_i == '0);
    assign accept   = start_i & ~busy_o;
    assign launch   = accept & ~cnt_zero;
    assign busy_o   = seq_active | tag.vld;
    assign done_o   = done_q;

    sig_addr_seq #(
        .AW (AW),
        .CW (CW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch_i  (launch),
        .base_i    (start_addr_i),
        .cnt_i     (word_cnt_i),
        .active_o  (seq_active),
        .rd_addr_o (mem_addr_o),
        .rd_en_o   (mem_re_o),
        .rd_last_o (seq_last)
    );

    sig_rd_track u_track (
        .clk       (clk),
        .rst       (rst),
        .rd_en_i   (mem_re_o),
        .rd_last_i (seq_last),
        .tag_o     (tag)
    );

    sig_misr u_misr (
        .clk      (clk),
        .rst      (rst),
        .seed_i   (accept),
        .absorb_i (tag.vld),
        .word_i   (mem_rdata_i),
        .sig_o    (sig_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (tag.vld & tag.last) | (accept & cnt_zero);
        end
    end

endmodule

// File: rtl/sig_gen_chk.sv
module sig_gen_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic [CW-1:0] word_cnt_i,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_re_o,
    input logic          busy_o,
    input logic          done_o,
    input logic [15:0]   sig_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && !mem_re_o && sig_o == 16'hFFFF));

    // R5
    read_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_re_o |-> busy_o);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R8
    sig_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(sig_o));

    // R6
    zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && word_cnt_i == '0) |=>
            (done_o && !mem_re_o && sig_o == 16'hFFFF));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_re_o && $past(mem_re_o)) |->
            (mem_addr_o == $past(mem_addr_o) + AW'(1) ||
             mem_addr_o == $past(mem_addr_o) - AW'(1) ||
             mem_addr_o == $past(mem_addr_o)));

endmodule

bind mem_sig_gen sig_gen_chk #(
    .AW (AW),
    .CW (CW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .word_cnt_i (word_cnt_i),
    .mem_addr_o (mem_addr_o),
    .mem_re_o   (mem_re_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sig_o      (sig_o)
);

// File: tb/mem_sig_gen_tb.sv
module mem_sig_gen_tb;

    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [AW-1:0] start_addr;
    logic [CW-1:0] word_cnt;
    logic [AW-1:0] mem_addr;
    logic          mem_re;
    logic [15:0]   mem_rdata;
    logic          busy;
    logic          done;
    logic [15:0]   sig;

    always #2 clk = ~clk;

    mem_sig_gen #(.AW(AW), .CW(CW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .start_addr_i (start_addr),
        .word_cnt_i   (word_cnt),
        .mem_addr_o   (mem_addr),
        .mem_re_o     (mem_re),
        .mem_rdata_i  (mem_rdata),
        .busy_o       (busy),
        .done_o       (done),
        .sig_o        (sig)
    );

    logic [15:0] mem [256];

    always_ff @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    int checks = 0;
    int fails  = 0;
    logic [AW-1:0] addr_q [$];
    logic [15:0]   sig_q  [$];
    logic [15:0]   last_sig;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_step(input logic [15:0] s, input logic [15:0] d);
        return d ^ {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    endfunction

    // Driver: predicts addresses and signature, then launches.
    task automatic run(input logic [AW-1:0] b, input int n, input bit interfere);
        logic [15:0] s;
        logic [AW-1:0] a;
        s = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            a = b + AW'(i);
            addr_q.push_back(a);
            s = model_step(s, mem[a[7:0]]);
        end
        for (int i = n - 1; i >= 0; i--) begin
            a = b + AW'(i);
            addr_q.push_back(a);
            s = model_step(s, mem[a[7:0]]);
        end
        sig_q.push_back(s);
        last_sig = s;
        @(negedge clk);
        start      = 1'b1;
        start_addr = b;
        word_cnt   = CW'(n);
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            check(done == 1'b1, "R6", "done after zero count", int'(done), 1);
            check(mem_re == 1'b0, "R6", "read on zero count", int'(mem_re), 0);
        end else begin
            check(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
        end
        if (interfere) begin
            repeat (2) @(negedge clk);
            // R7: second launch while busy must be ignored
            start      = 1'b1;
            start_addr = b + AW'(7);
            word_cnt   = CW'(3);
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops expectations as results appear.
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_re) begin
                if (addr_q.size() == 0) begin
                    check(1'b0, "R4", "extra read", int'(mem_addr), 0);
                end else begin
                    logic [AW-1:0] ea;
                    ea = addr_q.pop_front();
                    check(mem_addr == ea, "R3 R4", "read address", int'(mem_addr), int'(ea));
                end
            end
            if (done) begin
                check(busy == 1'b0, "R9", "busy at done", int'(busy), 0);
                check(addr_q.size() == 0, "R4", "reads missing at done", addr_q.size(), 0);
                if (sig_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected done", int'(sig), 0);
                end else begin
                    logic [15:0] es;
                    es = sig_q.pop_front();
                    check(sig == es, "R2 R5", "signature", int'(sig), int'(es));
                end
            end
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog expired: actual=%0h expected=%0h", 0, 1);
        summary();
        $finish;
    end

    initial begin
        rst        = 1'b1;
        start      = 1'b0;
        start_addr = '0;
        word_cnt   = '0;
        for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", int'({busy, done}), 0);
        check(sig == 16'hFFFF, "R1", "sig in reset", int'(sig), 16'hFFFF);
        check(mem_re == 1'b0, "R1", "read in reset", int'(mem_re), 0);
        rst = 1'b0;
        @(negedge clk);

        run(16'd10, 1, 1'b0);      // R4 single word absorbed twice
        run(16'd20, 2, 1'b0);
        run(16'd0, 0, 1'b0);       // R6
        run(16'd33, 5, 1'b0);
        run(16'hFFFE, 4, 1'b0);    // R3 wrap across the top
        run(16'd40, 12, 1'b1);     // R7 start while busy
        for (int k = 0; k < 8; k++) begin
            run(AW'($urandom % 256), 1 + int'($urandom % 40), 1'b0);
        end
        run(16'd90, 0, 1'b0);      // R6 again after nonzero run

        run(16'd100, 7, 1'b0);
        repeat (5) @(negedge clk);
        // R8: result held while idle
        check(sig == last_sig, "R8", "sig held while idle", int'(sig), int'(last_sig));
        check(busy == 1'b0, "R8", "idle after done", int'(busy), 0);

        summary();
        $finish;
    end

endmodule